// File: doc/BRIEF.md
# Multichannel Shadowed Pulse-Width Modulator

This block generates several independent pulse-width modulated outputs. Software programs it over a simple 32-bit write/read bus. Each channel has the following:
- a pending duty word;
- a pending period word, which holds the period count, two 2-bit output-level codes (one for the active phase, one for the inactive phase) and a 3-bit divider code;
- an enable bit in a shared control word.

Each channel counts divided clock ticks from zero up to its period value and then starts again. The output is in the active phase while the count is below the duty value.

Writing a duty or period word does not change the output straight away. A write to the period word arms an update. At the next period boundary the channel copies both pending words into its working registers together, so the waveform never shows a half-applied setting. A disabled channel takes an armed update at once. Each register can be written four ways, chosen by address bits 3:2:
- a plain write;
- a set of selected bits;
- a clear of selected bits;
- a toggle of selected bits.

This lets software flip single enable bits without a read-modify-write.

Top module: `pwm_multi`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: Address bits 3:2 select the write operation. The codes are: 0 replaces the register, 1 ORs the data into it, 2 clears the bits set in the data, and 3 inverts the bits set in the data. This applies to the control, duty and period registers alike.
- R3: The register map is as follows:
  - Control is at 0x00, and bit n enables channel n.
  - Channel n's duty register is at 0x10+n*0x20. Bits 31:16 hold the duty count, and bits 15:0 read zero.
  - Channel n's period register is at 0x20+n*0x20. It has these fields:
    - bits 15:0: period count;
    - bits 17:16: active-phase level code;
    - bits 19:18: inactive-phase level code;
    - bits 22:20: divider code;
    - bits 31:23: read zero.
  - Reads return the register whatever bits 3:2 hold.
  - A write whose address bits 1:0 are nonzero changes nothing.
- R4: An enabled channel with period count P and divider shift s repeats every (P+1)*2^s clock cycles.
- R5: The active phase lasts while the count is below the duty count D, so it is high for D*2^s cycles per period when D is at most P. Level code 3 drives high, and codes 0, 1 and 2 drive low. The output pin shows the state of the previous clock cycle.
- R6: Divider codes 0 to 7 give shifts of 0, 1, 2, 3, 4, 6, 8 and 10 bits.
- R7: A write to the duty register alone never changes the running waveform. A period write arms an update, which loads both pending words at the end of the current period.
- R8: A disabled channel drives its inactive level and holds its counter and divider at zero. It takes an armed update on the next cycle, and when enabled again its first active phase starts from count zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for counters and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the write operation |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | NCH | One modulated output per channel |

## Verification
Divider codes 0, 2, 5 and 7 are run with short periods. Codes 2 and 5 sit on either side of the point where the shift table stops rising by one, so a linear table shows up as a wrong period. The following level-code pairs are driven: high/low, low/high, the 0/1 codes and a constant high. Together they separate true level decoding from a plain inversion. A duty change made while the channel runs, first alone and then with its period write, shows whether updates wait for the boundary. A disable with an armed update, followed by re-enable, checks the immediate load and the restart from count zero. The set, clear and toggle codes are tried on the enable bits and on a period register.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
   localparam int unsigned CNT_W      = 16;
   localparam int unsigned DIV_CODE_W = 3;
   localparam int unsigned LVL_W      = 2;
   localparam int unsigned MAX_SHIFT  = 10;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLEAR = 2'd2,
      OP_FLIP  = 2'd3
   } bus_op_e;

   // field order is the software-visible layout of the period word
   typedef struct packed {
      logic [DIV_CODE_W-1:0] div_code;
      logic [LVL_W-1:0]      idle_lvl;
      logic [LVL_W-1:0]      busy_lvl;
      logic [CNT_W-1:0]      limit;
   } period_cfg_t;

   // shift grows by one up to code 4, then by two
   function automatic logic [3:0] div_shift(input logic [DIV_CODE_W-1:0] code);
      if (code < 3'd5) return {1'b0, code};
      else             return {code, 1'b0} - 4'd4;
   endfunction

   function automatic logic level_of(input logic [LVL_W-1:0] code);
      return code == 2'b11;
   endfunction

   function automatic logic merge_bit(input bus_op_e op, input logic cur, input logic wd);
      case (op)
         OP_WRITE: return wd;
         OP_SET:   return cur | wd;
         OP_CLEAR: return cur & ~wd;
         default:  return cur ^ wd;
      endcase
   endfunction
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs import pwm_pkg::*; #(
   parameter int unsigned NCH    = 2,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_we,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   output logic [NCH-1:0]              chan_en,
   output logic [NCH-1:0][CNT_W-1:0]   pend_duty,
   output period_cfg_t [NCH-1:0]       pend_cfg,
   output logic [NCH-1:0]              arm_pulse
);
   localparam int unsigned SLOT_W = ADDR_W - 4;
   localparam int unsigned CFG_W  = $bits(period_cfg_t);

   if (SLOT_W < 2 || (2 * NCH + 1) >= (1 << SLOT_W)) begin : g_bad_map
      $error("pwm_regs: address width too small for channel count");
   end

   logic              aligned;
   logic [SLOT_W-1:0] slot;
   bus_op_e           op;

   assign aligned = bus_addr[1:0] == 2'b00;
   assign slot    = bus_addr[ADDR_W-1:4];
   assign op      = bus_op_e'(bus_addr[3:2]);

   // control word
   logic           ctrl_hit;
   logic [NCH-1:0] ctrl_q;
   logic [NCH-1:0] ctrl_d;

   assign ctrl_hit = bus_we && aligned && (slot == '0);

   always_comb begin
      for (int b = 0; b < NCH; b++) begin
         ctrl_d[b] = merge_bit(op, ctrl_q[b], bus_wdata[b]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (ctrl_hit) ctrl_q <= ctrl_d;
   end

   assign chan_en = ctrl_q;

   // per-channel pending words
   for (genvar g = 0; g < NCH; g++) begin : g_chan
      localparam logic [SLOT_W-1:0] DUTY_SLOT = SLOT_W'(2 * g + 1);
      localparam logic [SLOT_W-1:0] CFG_SLOT  = SLOT_W'(2 * g + 2);

      logic             duty_hit;
      logic             cfg_hit;
      logic [CNT_W-1:0] duty_q;
      logic [CNT_W-1:0] duty_d;
      logic [CFG_W-1:0] cfg_q;
      logic [CFG_W-1:0] cfg_d;

      assign duty_hit = bus_we && aligned && (slot == DUTY_SLOT);
      assign cfg_hit  = bus_we && aligned && (slot == CFG_SLOT);

      always_comb begin
         for (int b = 0; b < CNT_W; b++) begin
            duty_d[b] = merge_bit(op, duty_q[b], bus_wdata[CNT_W + b]);
         end
         for (int b = 0; b < CFG_W; b++) begin
            cfg_d[b] = merge_bit(op, cfg_q[b], bus_wdata[b]);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            duty_q <= '0;
            cfg_q  <= '0;
         end else begin
            if (duty_hit) duty_q <= duty_d;
            if (cfg_hit)  cfg_q  <= cfg_d;
         end
      end

      assign pend_duty[g] = duty_q;
      assign pend_cfg[g]  = period_cfg_t'(cfg_q);
      assign arm_pulse[g] = cfg_hit;
   end

   // read mux: operation bits are ignored on reads
   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (slot == '0) bus_rdata = 32'(ctrl_q);
         for (int i = 0; i < NCH; i++) begin
            if (slot == SLOT_W'(2 * i + 1)) bus_rdata = {pend_duty[i], {CNT_W{1'b0}}};
            if (slot == SLOT_W'(2 * i + 2)) bus_rdata = {{(32 - CFG_W){1'b0}}, pend_cfg[i]};
         end
      end
   end

   // R2: set never drops a bit, clear never adds one, toggle flips exactly the data bits
   a_r2_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && op == OP_SET) |=> ((ctrl_q & $past(ctrl_q)) == $past(ctrl_q)));
   a_r2_clear_adds_none: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && op == OP_CLEAR) |=> ((ctrl_q & ~$past(ctrl_q)) == '0));
   a_r2_flip_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && op == OP_FLIP) |=> ((ctrl_q ^ $past(ctrl_q)) == $past(bus_wdata[NCH-1:0])));
   // R3: without a write strobe the control word holds
   a_r3_idle_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(ctrl_q));
endmodule

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale import pwm_pkg::*; #(
   parameter int unsigned ACC_W = MAX_SHIFT
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic [DIV_CODE_W-1:0] div_code,
   output logic                  tick
);
   if (ACC_W < MAX_SHIFT) begin : g_bad_acc
      $error("pwm_prescale: accumulator narrower than largest shift");
   end

   logic [3:0]       shift;
   logic [ACC_W-1:0] mask;
   logic [ACC_W-1:0] acc_q;

   assign shift = div_shift(div_code);

   always_comb begin
      for (int b = 0; b < ACC_W; b++) begin
         mask[b] = (4'(b) < shift);
      end
   end

   assign tick = run && (acc_q == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc_q <= '0;
      else if (!run)     acc_q <= '0;
      else if (tick)     acc_q <= '0;
      else               acc_q <= acc_q + ACC_W'(1);
   end

   // R6: accumulator never runs past the selected divide length
   a_r6_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q <= mask);
   // R8: a stopped channel restarts its divider from zero
   a_r8_div_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> acc_q == '0);
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel import pwm_pkg::*; #(
   parameter bit          OUT_REG = 1'b1,
   parameter int unsigned ACC_W   = MAX_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             arm,
   input  logic [CNT_W-1:0] pend_duty,
   input  period_cfg_t      pend_cfg,
   output logic             pwm_o
);
   logic             tick;
   logic             wrap;
   logic             commit;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] duty_w;
   period_cfg_t      cfg_w;
   logic             busy;
   logic             out_d;

   pwm_prescale #(.ACC_W(ACC_W)) u_prescale (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (en),
      .div_code (cfg_w.div_code),
      .tick     (tick)
   );

   assign wrap   = tick && (cnt_q == cfg_w.limit);
   assign commit = armed_q && (wrap || !en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!en)       cnt_q <= '0;
      else if (wrap)      cnt_q <= '0;
      else if (tick)      cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         armed_q <= 1'b0;
      else if (arm)       armed_q <= 1'b1;
      else if (commit)    armed_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_w <= '0;
         cfg_w  <= '0;
      end else if (commit) begin
         duty_w <= pend_duty;
         cfg_w  <= pend_cfg;
      end
   end

   assign busy  = en && (cnt_q < duty_w);
   assign out_d = busy ? level_of(cfg_w.busy_lvl) : level_of(cfg_w.idle_lvl);

   if (OUT_REG) begin : g_out_reg
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b0;
         else        out_q <= out_d;
      end
      assign pwm_o = out_q;
      // R8: a disabled channel shows its inactive level one cycle later
      a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> pwm_o == level_of($past(cfg_w.idle_lvl)));
   end else begin : g_out_comb
      assign pwm_o = out_d;
   end

   // R4: count stays inside the working period
   a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= cfg_w.limit);
   // R4: count only holds, steps by one, or returns to zero
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == '0));
   // R7: working settings move only at a period boundary while running
   a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wrap) |=> ($stable(duty_w) && $stable(cfg_w)));
   // R8: disabled channel clears its counter and takes an armed update at once
   a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt_q == '0);
   a_r8_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && armed_q && !arm) |=> (!armed_q && cfg_w == $past(pend_cfg)));
endmodule

// File: rtl/pwm_multi.sv
`timescale 1ns/1ps
module pwm_multi import pwm_pkg::*; #(
   parameter int unsigned NCH     = 2,
   parameter int unsigned ADDR_W  = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    pwm_o
);
   localparam int unsigned ACC_W = MAX_SHIFT;

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("pwm_multi: channel count must be 1 to 32");
   end
   if (ADDR_W > 16) begin : g_bad_addr
      $error("pwm_multi: address width above 16 is not supported");
   end

   logic [NCH-1:0]            chan_en;
   logic [NCH-1:0][CNT_W-1:0] pend_duty;
   period_cfg_t [NCH-1:0]     pend_cfg;
   logic [NCH-1:0]            arm_pulse;

   pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .chan_en   (chan_en),
      .pend_duty (pend_duty),
      .pend_cfg  (pend_cfg),
      .arm_pulse (arm_pulse)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      pwm_channel #(.OUT_REG(OUT_REG), .ACC_W(ACC_W)) u_channel (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (chan_en[g]),
         .arm       (arm_pulse[g]),
         .pend_duty (pend_duty[g]),
         .pend_cfg  (pend_cfg[g]),
         .pwm_o     (pwm_o[g])
      );
   end

   // R1: outputs are low in the first cycle after reset
   a_r1_low_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> pwm_o == '0);
endmodule

// File: tb/pwm_multi_bench.sv
`timescale 1ns/1ps
module pwm_multi_bench;
   localparam int NCH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] pwm_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwm_multi u_pwm_multi (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
   );

   // ---------------- reference model ----------------
   int shtab [8] = '{0, 1, 2, 3, 4, 6, 8, 10};
   logic [31:0] m_ctrl;
   logic [31:0] m_duty [NCH];
   logic [31:0] m_cfg  [NCH];
   logic [31:0] w_duty [NCH];
   logic [31:0] w_cfg  [NCH];
   int          m_cnt  [NCH];
   int          m_pre  [NCH];
   bit          m_arm  [NCH];
   bit          exp_out[NCH];

   function automatic logic [31:0] m_read(input logic [7:0] a);
      int r;
      if (a[1:0] != 2'b00) return 32'h0;
      r = int'(a >> 4);
      if (r == 0) return m_ctrl;
      for (int c = 0; c < NCH; c++) begin
         if (r == 2 * c + 1) return m_duty[c] << 16;
         if (r == 2 * c + 2) return m_cfg[c];
      end
      return 32'h0;
   endfunction

   function automatic logic [31:0] m_merge(input int op, input logic [31:0] cur, input logic [31:0] wd);
      case (op)
         0: return wd;
         1: return cur | wd;
         2: return cur & ~wd;
         default: return cur ^ wd;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 0;
         for (int c = 0; c < NCH; c++) begin
            m_duty[c] = 0; m_cfg[c] = 0; w_duty[c] = 0; w_cfg[c] = 0;
            m_cnt[c] = 0; m_pre[c] = 0; m_arm[c] = 0; exp_out[c] = 0;
         end
      end else begin
         int wr_cfg_ch;
         int r;
         wr_cfg_ch = -1;
         r = int'(bus_addr >> 4);
         if (bus_we && bus_addr[1:0] == 2'b00) begin
            for (int c = 0; c < NCH; c++) if (r == 2 * c + 2) wr_cfg_ch = c;
         end
         for (int c = 0; c < NCH; c++) begin
            bit en, busy, tick, wrap, commit;
            int code, sh, lim;
            en   = m_ctrl[c];
            busy = en && (m_cnt[c] < int'(w_duty[c]));
            code = busy ? int'((w_cfg[c] >> 16) & 3) : int'((w_cfg[c] >> 18) & 3);
            exp_out[c] = (code == 3);
            lim  = int'(w_cfg[c] & 32'hFFFF);
            sh   = shtab[(w_cfg[c] >> 20) & 7];
            tick = en && (m_pre[c] == (1 << sh) - 1);
            wrap = tick && (m_cnt[c] == lim);
            commit = m_arm[c] && (wrap || !en);
            if (!en || tick) m_pre[c] = 0; else m_pre[c] = m_pre[c] + 1;
            if (!en || wrap) m_cnt[c] = 0; else if (tick) m_cnt[c] = m_cnt[c] + 1;
            if (commit) begin w_duty[c] = m_duty[c]; w_cfg[c] = m_cfg[c]; end
            if (wr_cfg_ch == c) m_arm[c] = 1; else if (commit) m_arm[c] = 0;
         end
         if (bus_we && bus_addr[1:0] == 2'b00) begin
            logic [31:0] nv;
            nv = m_merge(int'(bus_addr[3:2]), m_read(bus_addr), bus_wdata);
            if (r == 0) m_ctrl = nv & ((32'd1 << NCH) - 1);
            for (int c = 0; c < NCH; c++) begin
               if (r == 2 * c + 1) m_duty[c] = (nv >> 16) & 32'hFFFF;
               if (r == 2 * c + 2) m_cfg[c]  = nv & 32'h007F_FFFF;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NCH; c++)
            chk(pwm_o[c] == exp_out[c], "R5 R8 output vs model", longint'(pwm_o[c]), longint'(exp_out[c]));
         chk(bus_rdata == m_read(bus_addr), "R3 readback vs model", longint'(bus_rdata), longint'(m_read(bus_addr)));
      end
   end

   // edge trackers
   bit prev_o   [NCH];
   int since    [NCH];
   int last_gap [NCH];
   int rise_cnt [NCH];
   int run_len  [NCH];
   int last_run [NCH];
   int fall_cnt [NCH];

   always @(negedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         since[c] = since[c] + 1;
         if (pwm_o[c] && !prev_o[c]) begin
            last_gap[c] = since[c]; since[c] = 0; rise_cnt[c] = rise_cnt[c] + 1;
         end
         if (pwm_o[c]) run_len[c] = run_len[c] + 1;
         else if (run_len[c] > 0) begin
            last_run[c] = run_len[c]; run_len[c] = 0; fall_cnt[c] = fall_cnt[c] + 1;
         end
         prev_o[c] = pwm_o[c];
      end
   end

   // ---------------- stimulus helpers ----------------
   localparam logic [7:0] CTRL = 8'h00;
   function automatic logic [7:0] duty_a(input int c); return 8'(8'h10 + c * 8'h20); endfunction
   function automatic logic [7:0] cfg_a(input int c);  return 8'(8'h20 + c * 8'h20); endfunction
   function automatic logic [31:0] cfg_w(input int per, input int bl, input int il, input int dv);
      return 32'(per) | (32'(bl) << 16) | (32'(il) << 18) | (32'(dv) << 20);
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0; bus_addr = 8'h00;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] expv, input string tag);
      @(posedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      chk(bus_rdata == expv, tag, longint'(bus_rdata), longint'(expv));
      bus_addr = 8'h00;
   endtask

   task automatic setup(input int c, input int duty, input logic [31:0] cfg);
      wr(CTRL + 8'h08, 32'd1 << c);
      wr(duty_a(c), 32'(duty) << 16);
      wr(cfg_a(c), cfg);
      wr(CTRL + 8'h04, 32'd1 << c);
   endtask

   task automatic high_in(input int c, input int n, output int h);
      h = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_o[c]) h++;
      end
   endtask

   task automatic period_of(input int c, output int g);
      int r0;
      r0 = rise_cnt[c];
      while (rise_cnt[c] < r0 + 3) @(negedge clk);
      g = last_gap[c];
   endtask

   task automatic wait_fall(input int c);
      int f0;
      f0 = fall_cnt[c];
      while (fall_cnt[c] == f0) @(negedge clk);
   endtask

   task automatic wait_rise(input int c);
      int r0;
      r0 = rise_cnt[c];
      while (rise_cnt[c] == r0) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      int h, g;
      for (int c = 0; c < NCH; c++) begin
         prev_o[c] = 0; since[c] = 0; last_gap[c] = 0; rise_cnt[c] = 0;
         run_len[c] = 0; last_run[c] = 0; fall_cnt[c] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(CTRL, 32'h0, "R1 control after reset");
      rd(duty_a(0), 32'h0, "R1 duty0 after reset");
      rd(cfg_a(0), 32'h0, "R1 period0 after reset");
      rd(cfg_a(1), 32'h0, "R1 period1 after reset");
      chk(pwm_o == '0, "R1 outputs low", longint'(pwm_o), 0);

      // R2 aliases on the enable bits
      wr(CTRL + 8'h04, 32'h1); rd(CTRL, 32'h1, "R2 set bit0");
      wr(CTRL + 8'h04, 32'h2); rd(CTRL, 32'h3, "R2 set bit1");
      wr(CTRL + 8'h08, 32'h1); rd(CTRL, 32'h2, "R2 clear bit0");
      wr(CTRL + 8'h0C, 32'h3); rd(CTRL, 32'h1, "R2 toggle both");
      wr(CTRL, 32'h0);         rd(CTRL, 32'h0, "R2 plain write");
      // R2 aliases on a period register
      wr(cfg_a(1) + 8'h04, 32'h0003_0000); rd(cfg_a(1), 32'h0003_0000, "R2 set period field");
      wr(cfg_a(1) + 8'h0C, 32'h0001_0001); rd(cfg_a(1), 32'h0002_0001, "R2 toggle period bits");
      wr(cfg_a(1) + 8'h08, 32'h0002_0000); rd(cfg_a(1), 32'h0000_0001, "R2 clear period bit");
      wr(cfg_a(1), 32'h0);

      // R3 field masks and unaligned writes
      wr(duty_a(0), 32'hFFFF_FFFF); rd(duty_a(0), 32'hFFFF_0000, "R3 duty low half reads zero");
      wr(cfg_a(0), 32'hFFFF_FFFF);  rd(cfg_a(0), 32'h007F_FFFF, "R3 period top bits read zero");
      rd(cfg_a(0) + 8'h08, 32'h007F_FFFF, "R3 read ignores operation bits");
      wr(8'h01, 32'h3);             rd(CTRL, 32'h0, "R3 unaligned write ignored");
      wr(duty_a(0), 32'h0); wr(cfg_a(0), 32'h0);

      // R4/R5 divider code 0
      setup(0, 2, cfg_w(4, 3, 2, 0));
      period_of(0, g); chk(g == 5, "R4 period code0 P=4", g, 5);
      high_in(0, 10, h); chk(h == 4, "R5 high time code0 D=2", h, 4);

      // R6 divider codes 2, 5, 7
      setup(0, 1, cfg_w(3, 3, 2, 2));
      period_of(0, g); chk(g == 16, "R6 period code2", g, 16);
      high_in(0, 32, h); chk(h == 8, "R6 high time code2", h, 8);
      setup(0, 1, cfg_w(1, 3, 2, 5));
      period_of(0, g); chk(g == 128, "R6 period code5", g, 128);
      high_in(0, 128, h); chk(h == 64, "R6 high time code5", h, 64);
      setup(0, 1, cfg_w(1, 3, 2, 7));
      period_of(0, g); chk(g == 2048, "R6 period code7", g, 2048);

      // R5 level codes on channel 1
      setup(1, 1, cfg_w(3, 2, 3, 0));
      repeat (6) @(negedge clk);
      high_in(1, 8, h); chk(h == 6, "R5 inverted levels", h, 6);
      setup(1, 1, cfg_w(3, 1, 0, 0));
      repeat (6) @(negedge clk);
      high_in(1, 8, h); chk(h == 0, "R5 codes 1 and 0 drive low", h, 0);
      setup(1, 1, cfg_w(3, 3, 3, 0));
      repeat (6) @(negedge clk);
      high_in(1, 8, h); chk(h == 8, "R5 code 3 both phases high", h, 8);

      // R7 mid-period update
      setup(0, 10, cfg_w(19, 3, 2, 0));
      repeat (25) @(negedge clk);
      wait_rise(0);
      wr(duty_a(0), 32'd15 << 16);
      wait_fall(0); chk(last_run[0] == 10, "R7 duty write alone not applied", last_run[0], 10);
      wait_fall(0); chk(last_run[0] == 10, "R7 duty write alone stays pending", last_run[0], 10);
      wait_rise(0);
      wr(cfg_a(0), cfg_w(19, 3, 2, 0));
      wait_fall(0); chk(last_run[0] == 10, "R7 armed update waits for boundary", last_run[0], 10);
      wait_fall(0); chk(last_run[0] == 15, "R7 update applied next period", last_run[0], 15);

      // R8 disable, immediate commit and restart
      wr(duty_a(0), 32'd4 << 16);
      wr(cfg_a(0), cfg_w(9, 2, 3, 0));
      wr(CTRL + 8'h08, 32'h1);
      repeat (3) @(negedge clk);
      high_in(0, 20, h); chk(h == 20, "R8 disabled holds inactive high", h, 20);
      wr(cfg_a(0), cfg_w(9, 3, 2, 0));
      repeat (3) @(negedge clk);
      high_in(0, 10, h); chk(h == 0, "R8 armed update taken while disabled", h, 0);
      wr(CTRL + 8'h04, 32'h1);
      @(negedge clk); chk(pwm_o[0] == 1'b0, "R8 still idle on enable cycle", longint'(pwm_o[0]), 0);
      @(negedge clk); chk(pwm_o[0] == 1'b1, "R8 active phase starts", longint'(pwm_o[0]), 1);
      wait_fall(0); chk(last_run[0] == 4, "R8 restart from count zero", last_run[0], 4);

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule